// File: doc/BRIEF.md
# Register Reservation Hazard Detector

This block sits at the issue point of an in-order pipeline. It decides, each cycle, whether the instruction offered for issue may leave. It keeps two bit vectors with one bit per architectural register. The write-reservation vector marks registers that an in-flight instruction will still write. The outstanding-read vector marks registers that an in-flight instruction has not yet read.

The offered instruction has up to two source registers and one destination register, each with its own valid bit. They are compared against both vectors. This finds read-after-write (RAW), write-after-write (WAW) and write-after-read (WAR) conflicts. Each hazard type is reported on its own flag, and any of them raises the stall output. An instruction that issues without a stall reserves its destination and marks its sources as outstanding reads. A completion report clears a write reservation. A read-done report clears an outstanding read.

Register 0 is hard-wired and never takes part. The reset input is asynchronous and active-low. Its release reaches the logic through a two-stage synchronizer.

Top module: `issue_hazard_guard`

## Requirements
- R1: While reset is applied, and after its release, both vectors are empty. No flag and no stall is raised for any request until a later issue makes a reservation.
- R2: `haz_raw` is high when `iss_valid` is high and a valid, non-zero source matches a register in the write-reservation vector.
- R3: `haz_waw` is high when `iss_valid` is high and the valid, non-zero destination matches a register in the write-reservation vector.
- R4: `haz_war` is high when `iss_valid` is high and the valid, non-zero destination matches a register in the outstanding-read vector.
- R5: `stall` equals `iss_valid` AND (`haz_raw` OR `haz_waw` OR `haz_war`). With `iss_valid` low, all flags and `stall` are low, whatever the operand fields hold.
- R6: An issue without a stall reserves its valid destination and marks its valid sources as outstanding reads. Both take effect from the next cycle.
- R7: A completion (`done_vld`, `done_reg`) clears that write reservation. A read-done (`rdone_vld`, `rdone_reg`) clears that outstanding read. Both take effect from the next cycle.
- R8: Hazards are judged on the state held at the start of the cycle. A clear arriving in the same cycle does not remove a hazard in that cycle. When a clear and an issue name the same register in one cycle, the clear is applied first and the register ends up set.
- R9: Register 0 is never reserved, never marked as read, and never causes a hazard.
- R10: A stalled issue changes neither vector.
- R11: An operand whose valid bit is low is ignored, both for hazard detection and for the vector updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction is offered for issue |
| src_a_vld | input | 1 | First source is used |
| src_a | input | 5 | First source register number |
| src_b_vld | input | 1 | Second source is used |
| src_b | input | 5 | Second source register number |
| dst_vld | input | 1 | Destination is used |
| dst | input | 5 | Destination register number |
| done_vld | input | 1 | A write completed this cycle |
| done_reg | input | 5 | Register whose write completed |
| rdone_vld | input | 1 | An operand read completed this cycle |
| rdone_reg | input | 5 | Register whose read completed |
| stall | output | 1 | Hold the offered instruction |
| haz_raw | output | 1 | Read-after-write conflict |
| haz_waw | output | 1 | Write-after-write conflict |
| haz_war | output | 1 | Write-after-read conflict |

## Verification
The flags and `stall` are combinational from the request. They are due in the same cycle as the request. The bench therefore drives each request just after a falling edge and samples 1 ns later, before the next rising edge.

Vector updates from an issue, a completion or a read-done appear only after that rising edge. Each table row's expected flags are worked out from the state left by the rows before it. Same-cycle clear-and-issue rows pin down the ordering in R8.

After reset release, the bench waits three cycles so the two synchronizer stages have let go before it checks again.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int NREG_DEF   = 32;
  localparam int SYNC_DEF   = 2;
  localparam int NSRC       = 2;
endpackage

// File: rtl/hz_rst_sync.sv
module hz_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/hz_resv_table.sv
module hz_resv_table #(
  parameter  int NREG = 32,
  parameter  int NSET = 1,
  localparam int IW   = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic [NSET-1:0]          set_en,
  input  logic [NSET-1:0][IW-1:0]  set_idx,
  input  logic                     clr_en,
  input  logic [IW-1:0]            clr_idx,
  output logic [NREG-1:0]          bits_o
);
  logic [NREG-1:0] bits_q, bits_d, set_mask, clr_mask;
  logic [NSET-1:0][NREG-1:0] set_dec;
  logic upd_en, clr_hit_set;

  // one-hot decode per set port
  for (genvar g = 0; g < NSET; g++) begin : g_dec
    assign set_dec[g] = set_en[g] ? (NREG'(1) << set_idx[g]) : '0;
  end

  always_comb begin
    set_mask    = '0;
    clr_hit_set = 1'b0;
    for (int i = 0; i < NSET; i++) begin
      set_mask = set_mask | set_dec[i];
      if (set_en[i] && set_idx[i] == clr_idx) clr_hit_set = 1'b1;
    end
    clr_mask = clr_en ? (NREG'(1) << clr_idx) : '0;
    // clear first, then set; entry 0 is hard-wired empty
    bits_d    = (bits_q & ~clr_mask) | set_mask;
    bits_d[0] = 1'b0;
  end

  assign upd_en = clr_en | (|set_en);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     bits_q <= '0;
    else if (upd_en) bits_q <= bits_d;
  end

  assign bits_o = bits_q;

  AST_ZERO_EMPTY: assert property (@(posedge clk) disable iff (!rst_ni)
    !bits_q[0]); // R9

  AST_CLEAR_THEN_SET: assert property (@(posedge clk) disable iff (!rst_ni)
    (set_en[0] && clr_en && clr_idx == set_idx[0] && set_idx[0] != '0)
    |=> bits_q[$past(set_idx[0])]); // R8

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_en && !clr_hit_set) |=> !bits_q[$past(clr_idx)]); // R7
endmodule

// File: rtl/hz_compare.sv
module hz_compare #(
  parameter  int NREG = 32,
  localparam int IW   = $clog2(NREG)
) (
  input  logic [NREG-1:0] wr_bits,
  input  logic [NREG-1:0] rd_bits,
  input  logic            iss_valid,
  input  logic            src_a_vld,
  input  logic [IW-1:0]   src_a,
  input  logic            src_b_vld,
  input  logic [IW-1:0]   src_b,
  input  logic            dst_vld,
  input  logic [IW-1:0]   dst,
  output logic            raw,
  output logic            waw,
  output logic            war
);
  function automatic logic hit(input logic [NREG-1:0] vec,
                               input logic vld, input logic [IW-1:0] idx);
    return vld && (idx != '0) && vec[idx];
  endfunction

  always_comb begin
    raw = iss_valid && (hit(wr_bits, src_a_vld, src_a) || hit(wr_bits, src_b_vld, src_b));
    waw = iss_valid && hit(wr_bits, dst_vld, dst);
    war = iss_valid && hit(rd_bits, dst_vld, dst);
  end
endmodule

// File: rtl/issue_hazard_guard.sv
module issue_hazard_guard #(
  parameter  int NREG  = hz_pkg::NREG_DEF,
  parameter  int SYNC  = hz_pkg::SYNC_DEF,
  localparam int IW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          iss_valid,
  input  logic          src_a_vld,
  input  logic [IW-1:0] src_a,
  input  logic          src_b_vld,
  input  logic [IW-1:0] src_b,
  input  logic          dst_vld,
  input  logic [IW-1:0] dst,
  input  logic          done_vld,
  input  logic [IW-1:0] done_reg,
  input  logic          rdone_vld,
  input  logic [IW-1:0] rdone_reg,
  output logic          stall,
  output logic          haz_raw,
  output logic          haz_waw,
  output logic          haz_war
);
  logic rst_sn;
  logic issue_go;
  logic [NREG-1:0] wr_bits, rd_bits;
  logic [hz_pkg::NSRC-1:0] rd_set_en;
  logic [hz_pkg::NSRC-1:0][IW-1:0] rd_set_idx;

  hz_rst_sync #(.STAGES(SYNC)) u_rst (
    .clk(clk), .rst_ni(rst_ni), .rst_no(rst_sn)
  );

  hz_compare #(.NREG(NREG)) u_cmp (
    .wr_bits(wr_bits), .rd_bits(rd_bits), .iss_valid(iss_valid),
    .src_a_vld(src_a_vld), .src_a(src_a), .src_b_vld(src_b_vld), .src_b(src_b),
    .dst_vld(dst_vld), .dst(dst),
    .raw(haz_raw), .waw(haz_waw), .war(haz_war)
  );

  assign stall    = iss_valid & (haz_raw | haz_waw | haz_war);
  assign issue_go = iss_valid & ~stall;

  assign rd_set_en  = {issue_go & src_b_vld, issue_go & src_a_vld};
  assign rd_set_idx = {src_b, src_a};

  hz_resv_table #(.NREG(NREG), .NSET(1)) u_wr (
    .clk(clk), .rst_ni(rst_sn),
    .set_en(issue_go & dst_vld), .set_idx(dst),
    .clr_en(done_vld), .clr_idx(done_reg),
    .bits_o(wr_bits)
  );

  hz_resv_table #(.NREG(NREG), .NSET(hz_pkg::NSRC)) u_rd (
    .clk(clk), .rst_ni(rst_sn),
    .set_en(rd_set_en), .set_idx(rd_set_idx),
    .clr_en(rdone_vld), .clr_idx(rdone_reg),
    .bits_o(rd_bits)
  );

  AST_STALL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_sn)
    stall |-> iss_valid); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    !iss_valid |-> !(haz_raw || haz_waw || haz_war)); // R5

  AST_ISSUE_RESERVES: assert property (@(posedge clk) disable iff (!rst_sn)
    (issue_go && dst_vld && dst != '0) |=> wr_bits[$past(dst)]); // R6

  AST_STALL_NO_RESERVE: assert property (@(posedge clk) disable iff (!rst_sn)
    (stall && dst_vld && dst != '0 && !wr_bits[dst]) |=> !wr_bits[$past(dst)]); // R10
endmodule

// File: tb/issue_hazard_guard_test.sv
`timescale 1ns/1ps
module issue_hazard_guard_test;
  typedef struct packed {
    logic iss; logic av; logic [4:0] a; logic bv; logic [4:0] b;
    logic dv; logic [4:0] d; logic cv; logic [4:0] c; logic rv; logic [4:0] r;
    logic [3:0] exp;   // {stall, raw, waw, war}
    logic [3:0] req;
  } vec_t;

  // Row order matters: each row's expectation follows from earlier rows.
  localparam int NV = 26;
  localparam vec_t TBL [NV] = '{
    '{0,0,0,0,0,0,0,0,0,0,0,4'b0000,1},  // R1 idle after reset
    '{1,1,1,1,2,1,3,0,0,0,0,4'b0000,6},  // R6 reads 1,2 writes 3
    '{1,1,3,0,0,1,4,0,0,0,0,4'b1100,2},  // R2 read of 3
    '{1,1,5,1,6,1,7,0,0,0,0,4'b0000,6},  // R6 reads 5,6 writes 7
    '{1,0,0,0,0,1,7,0,0,0,0,4'b1010,3},  // R3 write of 7
    '{1,0,0,0,0,1,2,0,0,0,0,4'b1001,4},  // R4 write of 2
    '{1,0,0,1,7,1,1,0,0,0,0,4'b1101,2},  // R2 plus WAR on 1
    '{0,0,0,0,0,0,0,1,3,0,0,4'b0000,7},  // R7 complete 3
    '{1,1,3,0,0,1,8,0,0,0,0,4'b0000,7},  // R7 read 3 now free
    '{0,0,0,0,0,0,0,0,0,1,2,4'b0000,7},  // R7 read-done 2
    '{1,1,0,0,0,1,2,0,0,0,0,4'b0000,4},  // R4 WAR on 2 gone
    '{1,0,7,0,0,0,8,0,0,0,0,4'b0000,11}, // R11 invalid fields
    '{1,1,0,0,0,1,0,0,0,0,0,4'b0000,9},  // R9 register 0
    '{1,0,0,0,0,1,9,1,9,0,0,4'b0000,8},  // R8 clear+set on 9
    '{1,0,0,1,9,0,0,0,0,0,0,4'b1100,8},  // R8 9 stayed reserved
    '{1,1,7,0,0,0,0,1,7,0,0,4'b1100,8},  // R8 same-cycle clear ignored
    '{1,1,7,0,0,0,0,0,0,0,0,4'b0000,7},  // R7 7 now free
    '{1,0,0,0,0,1,7,0,0,0,0,4'b1001,6},  // R6 read mark on 7
    '{0,0,0,0,0,0,0,0,0,1,7,4'b0000,7},  // R7 read-done 7
    '{1,0,0,0,0,1,7,0,0,0,0,4'b0000,7},  // R7 write 7 accepted
    '{1,1,7,0,0,0,0,0,0,0,0,4'b1100,6},  // R6 7 reserved
    '{0,1,7,0,0,1,8,0,0,0,0,4'b0000,5},  // R5 no issue, no flags
    '{1,1,4,0,0,0,0,0,0,0,0,4'b0000,10}, // R10 stalled write of 4 left nothing
    '{1,0,0,0,0,1,3,0,0,0,0,4'b1001,4},  // R4 read mark on 3
    '{1,0,0,0,0,1,1,0,0,1,1,4'b1001,8},  // R8 same-cycle read-done ignored
    '{1,0,0,0,0,1,1,0,0,0,0,4'b0000,7}   // R7 read mark on 1 gone
  };

  logic clk = 1'b0;
  logic rst_ni;
  logic iss_valid, src_a_vld, src_b_vld, dst_vld, done_vld, rdone_vld;
  logic [4:0] src_a, src_b, dst, done_reg, rdone_reg;
  logic stall, haz_raw, haz_waw, haz_war;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  issue_hazard_guard uut (
    .clk(clk), .rst_ni(rst_ni), .iss_valid(iss_valid),
    .src_a_vld(src_a_vld), .src_a(src_a), .src_b_vld(src_b_vld), .src_b(src_b),
    .dst_vld(dst_vld), .dst(dst), .done_vld(done_vld), .done_reg(done_reg),
    .rdone_vld(rdone_vld), .rdone_reg(rdone_reg),
    .stall(stall), .haz_raw(haz_raw), .haz_waw(haz_waw), .haz_war(haz_war)
  );

  task automatic apply(input vec_t v);
    iss_valid = v.iss; src_a_vld = v.av; src_a = v.a; src_b_vld = v.bv; src_b = v.b;
    dst_vld = v.dv; dst = v.d; done_vld = v.cv; done_reg = v.c;
    rdone_vld = v.rv; rdone_reg = v.r;
  endtask

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {stall, haz_raw, haz_waw, haz_war};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {stall,raw,waw,war} actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic vec_t req_of(input logic iss, input logic av, input logic [4:0] a,
                                  input logic dv, input logic [4:0] d);
    vec_t v;
    v = '0;
    v.iss = iss; v.av = av; v.a = a; v.dv = dv; v.d = d;
    return v;
  endfunction

  initial begin
    apply('0);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk("R1", 4'b0000);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(TBL[i]);
      #1 chk($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].exp);
    end

    // R1: reset in mid-run clears 7, 2, 9 reservations
    @(negedge clk);
    apply('0);
    rst_ni = 1'b0;
    @(negedge clk);
    apply(req_of(1, 1, 5'd7, 1, 5'd2));
    #1 chk("R1 during reset", 4'b0000);
    @(negedge clk);
    rst_ni = 1'b1;
    apply('0);
    repeat (3) @(negedge clk);
    apply(req_of(1, 1, 5'd9, 1, 5'd2));
    #1 chk("R1 after release", 4'b0000);

    // R6 sweep: reserve every register (the request above reserved 2 and read 9)
    @(negedge clk);
    apply('0); rdone_vld = 1'b1; rdone_reg = 5'd9; done_vld = 1'b1; done_reg = 5'd2;
    for (int k = 1; k < 32; k++) begin
      @(negedge clk);
      apply(req_of(1, 0, 5'd0, 1, 5'(k)));
      #1 chk("R6 sweep reserve", 4'b0000);
    end
    // R2 / R9: every nonzero register now raises RAW, register 0 never
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      apply(req_of(1, 1, 5'(k), 0, 5'd0));
      #1 chk(k == 0 ? "R9 source 0" : "R2 sweep read", k == 0 ? 4'b0000 : 4'b1100);
    end
    // R7: complete every register, then nothing is reserved
    for (int k = 1; k < 32; k++) begin
      @(negedge clk);
      apply('0); done_vld = 1'b1; done_reg = 5'(k);
    end
    @(negedge clk);
    apply(req_of(1, 1, 5'd31, 1, 5'd17)); src_b_vld = 1'b1; src_b = 5'd1;
    #1 chk("R7 all cleared", 4'b0000);

    @(negedge clk);
    apply('0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #50000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule